// File: doc/BRIEF.md
# Virtual Terminal Channel Multiplexer

This block lets several virtual terminal channels share a single physical byte link. On the user side every channel has its own transmit and receive queue, each with a valid/ready handshake. On the link side every character travels as a two-byte frame. The first byte names the channel and the second byte carries the character.

Transmit side: an arbiter visits the channels that have queued characters in round-robin order. For the chosen channel it sends the channel number and then one character, and the two bytes are never split.

Receive side: incoming bytes are taken as index/character pairs, and each character goes into the receive queue of the channel its index names. The three terminal control codes are not queued. Each one is turned into a one-cycle event pulse on that channel's matching side-band output. A pair whose index names no existing channel is dropped. When the target receive queue is full, the link input is held off and no data is lost.

Top module: `vchan_mux`

## Requirements
- R1: After reset, `link_tx_valid`, every `usr_rx_valid` bit and every event output are 0. Every `usr_tx_ready` bit and `link_rx_ready` are 1.
- R2: Each transmitted frame is two link bytes: the channel number (0..N_CH-1), then the character. While `link_tx_valid` is 1 and `link_tx_ready` is 0, the valid flag and the byte stay unchanged.
- R3: The transmit arbiter searches from the channel after the last one served, wrapping from N_CH-1 to 0. Channel 0 is searched first after reset. One character is sent per grant.
- R4: Once the index byte of a frame is accepted, the next byte on the link is that frame's character. No other frame starts between them.
- R5: The characters of one channel leave on the link in the order they were written.
- R6: `usr_tx_ready[c]` is 0 exactly while channel c's transmit queue holds DEPTH characters.
- R7: A received index byte i < N_CH followed by a character byte c (other than 0x03, 0x04 or 0x1A) appends c to channel i's receive queue. Per-channel order is kept.
- R8: `usr_rx_valid[c]` is 1 exactly while channel c's receive queue is non-empty. `usr_rx_data` slice c shows the oldest entry.
- R9: The character 0x03, 0x04 or 0x1A, received for channel i, is not queued. In the cycle after its byte is accepted, bit i of `ev_intr`, `ev_eof` or `ev_susp` respectively is 1 for exactly one cycle.
- R10: A received index byte >= N_CH causes the next byte to be accepted and discarded, with no queue write and no event. The byte after that is treated as an index.
- R11: While a character byte targets a full receive queue, `link_rx_ready` is 0. The byte is accepted once a slot frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_tx_valid | input | N_CH | Per-channel character write request |
| usr_tx_data | input | N_CH*8 | Per-channel character, channel c in bits [8c+7:8c] |
| usr_tx_ready | output | N_CH | Per-channel transmit queue not full |
| usr_rx_valid | output | N_CH | Per-channel receive queue not empty |
| usr_rx_data | output | N_CH*8 | Per-channel oldest received character |
| usr_rx_ready | input | N_CH | Per-channel read acknowledge |
| link_tx_valid | output | 1 | Outgoing link byte valid |
| link_tx_data | output | 8 | Outgoing link byte |
| link_tx_ready | input | 1 | Link accepts the outgoing byte |
| link_rx_valid | input | 1 | Incoming link byte valid |
| link_rx_data | input | 8 | Incoming link byte |
| link_rx_ready | output | 1 | Block accepts the incoming byte |
| ev_intr | output | N_CH | One-cycle pulse on received 0x03 |
| ev_eof | output | N_CH | One-cycle pulse on received 0x04 |
| ev_susp | output | N_CH | One-cycle pulse on received 0x1A |

## Verification
The bench stalls the link with several channels pending and then checks the exact byte order. A wrong round-robin pointer would serve channel 0 twice before channel 2. A broken frame lock would let a header follow a header.

It fills queues to DEPTH on both sides. A wrong full flag would either drop characters or refuse writes early. A missing receive stall would lose the character that arrives for a full queue.

Control codes and out-of-range indices are sent between ordinary pairs. A design that queued control codes, pulsed the wrong event line, or lost track of byte pairing after a discarded frame would deliver wrong or shifted characters.

// File: rtl/vchan_mux_pkg.sv
package vchan_mux_pkg;
    localparam logic [7:0] CC_INTR = 8'h03;
    localparam logic [7:0] CC_EOF  = 8'h04;
    localparam logic [7:0] CC_SUSP = 8'h1A;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HDR  = 2'd1,
        TX_BODY = 2'd2
    } tx_st_e;
endpackage

// File: rtl/vchan_fifo.sv
module vchan_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]  wr;
        logic [PW-1:0]  rd;
        logic [CNW-1:0] cnt;
    } st_t;

    st_t q, d;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        d = q;
        if (push) d.wr = (q.wr == PW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        if (pop)  d.rd = (q.rd == PW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        if (push && !pop)      d.cnt = q.cnt + 1'b1;
        else if (pop && !push) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[q.wr] <= wdata;
    end

    assign rdata = mem_q[q.rd];
    assign full  = (q.cnt == CNW'(DEPTH));
    assign empty = (q.cnt == '0);

    // R6
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |-> !push);
    // R5
    fifo_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/vchan_tx.sv
module vchan_tx
    import vchan_mux_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   nonempty,
    input  logic [N_CH*8-1:0] rdata,
    output logic [N_CH-1:0]   pop,
    output logic              link_tx_valid,
    output logic [7:0]        link_tx_data,
    input  logic              link_tx_ready
);
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

    typedef struct packed {
        tx_st_e        st;
        logic [CW-1:0] sel;
        logic [CW-1:0] rr;
    } st_t;

    st_t q, d;
    logic          found;
    logic [CW-1:0] pick;
    int            c;

    always_comb begin
        d     = q;
        pop   = '0;
        found = 1'b0;
        pick  = '0;
        c     = 0;
        for (int k = 0; k < N_CH; k++) begin
            c = int'(q.rr) + k;
            if (c >= N_CH) c = c - N_CH;
            if (!found && nonempty[c]) begin
                found = 1'b1;
                pick  = CW'(c);
            end
        end
        case (q.st)
            TX_IDLE: if (found) begin
                d.st  = TX_HDR;
                d.sel = pick;
            end
            TX_HDR: if (link_tx_ready) d.st = TX_BODY;
            TX_BODY: if (link_tx_ready) begin
                pop[q.sel] = 1'b1;
                d.st = TX_IDLE;
                d.rr = (int'(q.sel) == N_CH - 1) ? '0 : q.sel + 1'b1;
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: TX_IDLE, sel: '0, rr: '0};
        else        q <= d;
    end

    assign link_tx_valid = (q.st != TX_IDLE);
    assign link_tx_data  = (q.st == TX_HDR) ? 8'(q.sel) : rdata[q.sel*8 +: 8];

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_tx_valid && !link_tx_ready) |=> (link_tx_valid && $stable(link_tx_data)));
    // R4
    tx_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_HDR && link_tx_ready) |=> (link_tx_valid && $stable(q.sel)));
endmodule

// File: rtl/vchan_rx.sv
module vchan_rx
    import vchan_mux_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_rx_valid,
    input  logic [7:0]      link_rx_data,
    output logic            link_rx_ready,
    input  logic [N_CH-1:0] full,
    output logic [N_CH-1:0] push,
    output logic [N_CH-1:0] ev_intr,
    output logic [N_CH-1:0] ev_eof,
    output logic [N_CH-1:0] ev_susp
);
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

    typedef struct packed {
        logic            have_idx;
        logic [7:0]      idx;
        logic [N_CH-1:0] intr;
        logic [N_CH-1:0] eof;
        logic [N_CH-1:0] susp;
    } st_t;

    st_t q, d;
    logic          idx_ok;
    logic          is_ctl;
    logic [CW-1:0] ch;
    logic          accept;

    always_comb begin
        d      = q;
        d.intr = '0;
        d.eof  = '0;
        d.susp = '0;
        push   = '0;
        idx_ok = (int'(q.idx) < N_CH);
        ch     = q.idx[CW-1:0];
        is_ctl = (link_rx_data == CC_INTR) || (link_rx_data == CC_EOF) ||
                 (link_rx_data == CC_SUSP);
        link_rx_ready = !q.have_idx || !idx_ok || is_ctl || !full[ch];
        accept = link_rx_valid && link_rx_ready;
        if (accept) begin
            if (!q.have_idx) begin
                d.have_idx = 1'b1;
                d.idx      = link_rx_data;
            end else begin
                d.have_idx = 1'b0;
                if (idx_ok) begin
                    if (link_rx_data == CC_INTR)      d.intr[ch] = 1'b1;
                    else if (link_rx_data == CC_EOF)  d.eof[ch]  = 1'b1;
                    else if (link_rx_data == CC_SUSP) d.susp[ch] = 1'b1;
                    else                              push[ch]   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ev_intr = q.intr;
    assign ev_eof  = q.eof;
    assign ev_susp = q.susp;

    // R9
    rx_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_intr, ev_eof, ev_susp}));
    // R11
    rx_nodrop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push & full) == '0);
endmodule

// File: rtl/vchan_mux.sv
module vchan_mux #(
    parameter int N_CH  = 4,
    parameter int DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   usr_tx_valid,
    input  logic [N_CH*8-1:0] usr_tx_data,
    output logic [N_CH-1:0]   usr_tx_ready,
    output logic [N_CH-1:0]   usr_rx_valid,
    output logic [N_CH*8-1:0] usr_rx_data,
    input  logic [N_CH-1:0]   usr_rx_ready,
    output logic              link_tx_valid,
    output logic [7:0]        link_tx_data,
    input  logic              link_tx_ready,
    input  logic              link_rx_valid,
    input  logic [7:0]        link_rx_data,
    output logic              link_rx_ready,
    output logic [N_CH-1:0]   ev_intr,
    output logic [N_CH-1:0]   ev_eof,
    output logic [N_CH-1:0]   ev_susp
);
    logic [N_CH-1:0]   tx_full, tx_empty, tx_pop;
    logic [N_CH*8-1:0] tx_rdata;
    logic [N_CH-1:0]   rx_full, rx_empty, rx_push;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        vchan_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (usr_tx_valid[i] && !tx_full[i]),
            .wdata (usr_tx_data[i*8 +: 8]),
            .pop   (tx_pop[i]),
            .rdata (tx_rdata[i*8 +: 8]),
            .full  (tx_full[i]),
            .empty (tx_empty[i])
        );
        vchan_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (rx_push[i]),
            .wdata (link_rx_data),
            .pop   (usr_rx_ready[i] && !rx_empty[i]),
            .rdata (usr_rx_data[i*8 +: 8]),
            .full  (rx_full[i]),
            .empty (rx_empty[i])
        );
    end

    assign usr_tx_ready = ~tx_full;
    assign usr_rx_valid = ~rx_empty;

    vchan_tx #(.N_CH(N_CH)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .nonempty      (~tx_empty),
        .rdata         (tx_rdata),
        .pop           (tx_pop),
        .link_tx_valid (link_tx_valid),
        .link_tx_data  (link_tx_data),
        .link_tx_ready (link_tx_ready)
    );

    vchan_rx #(.N_CH(N_CH)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_rx_valid (link_rx_valid),
        .link_rx_data  (link_rx_data),
        .link_rx_ready (link_rx_ready),
        .full          (rx_full),
        .push          (rx_push),
        .ev_intr       (ev_intr),
        .ev_eof        (ev_eof),
        .ev_susp       (ev_susp)
    );
endmodule

// File: tb/vchan_mux_tb.sv
`timescale 1ns/100ps
module vchan_mux_tb;
    localparam int N  = 4;
    localparam int DP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   usr_tx_valid = '0;
    logic [N*8-1:0] usr_tx_data = '0;
    logic [N-1:0]   usr_tx_ready;
    logic [N-1:0]   usr_rx_valid;
    logic [N*8-1:0] usr_rx_data;
    logic [N-1:0]   usr_rx_ready = '0;
    logic           link_tx_valid;
    logic [7:0]     link_tx_data;
    logic           link_tx_ready = 1'b0;
    logic           link_rx_valid = 1'b0;
    logic [7:0]     link_rx_data = '0;
    logic           link_rx_ready;
    logic [N-1:0]   ev_intr, ev_eof, ev_susp;

    int total = 0;
    int bad = 0;
    logic [7:0] cap [16];
    int ncap;

    always #2.5 clk = ~clk;

    vchan_mux #(.N_CH(N), .DEPTH(DP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .usr_tx_valid(usr_tx_valid), .usr_tx_data(usr_tx_data), .usr_tx_ready(usr_tx_ready),
        .usr_rx_valid(usr_rx_valid), .usr_rx_data(usr_rx_data), .usr_rx_ready(usr_rx_ready),
        .link_tx_valid(link_tx_valid), .link_tx_data(link_tx_data), .link_tx_ready(link_tx_ready),
        .link_rx_valid(link_rx_valid), .link_rx_data(link_rx_data), .link_rx_ready(link_rx_ready),
        .ev_intr(ev_intr), .ev_eof(ev_eof), .ev_susp(ev_susp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic push_tx(input int ch, input logic [7:0] b);
        @(negedge clk);
        usr_tx_valid[ch] = 1'b1;
        usr_tx_data[ch*8 +: 8] = b;
        @(negedge clk);
        usr_tx_valid[ch] = 1'b0;
    endtask

    task automatic collect(input int n);
        ncap = 0;
        @(negedge clk);
        link_tx_ready = 1'b1;
        for (int t = 0; t < 200 && ncap < n; t++) begin
            #2;
            if (link_tx_valid) begin
                cap[ncap] = link_tx_data;
                ncap++;
            end
            @(negedge clk);
        end
        link_tx_ready = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk);
        link_rx_valid = 1'b1;
        link_rx_data = b;
        for (int t = 0; t < 200; t++) begin
            #2;
            if (link_rx_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #0.5;
        link_rx_valid = 1'b0;
    endtask

    task automatic pop_rx(input int ch, input logic [7:0] exp, input string req);
        @(negedge clk);
        #1;
        chk({req, " rx valid"}, usr_rx_valid[ch], 1'b1);
        chk({req, " rx data"}, usr_rx_data[ch*8 +: 8], exp);
        usr_rx_ready[ch] = 1'b1;
        @(posedge clk);
        #0.5;
        usr_rx_ready[ch] = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 link_tx_valid", link_tx_valid, 1'b0);
        chk("R1 usr_rx_valid", usr_rx_valid, '0);
        chk("R1 usr_tx_ready", usr_tx_ready, {N{1'b1}});
        chk("R1 link_rx_ready", link_rx_ready, 1'b1);
        chk("R1 events", {ev_intr, ev_eof, ev_susp}, '0);
    endtask

    task automatic t_tx_rr();
        logic [7:0] exp [8];
        exp = '{8'd0, 8'h41, 8'd1, 8'h43, 8'd2, 8'h44, 8'd0, 8'h42};
        push_tx(0, 8'h41);
        push_tx(0, 8'h42);
        push_tx(1, 8'h43);
        push_tx(2, 8'h44);
        repeat (2) @(negedge clk);
        #1;
        chk("R2 held valid", link_tx_valid, 1'b1);
        chk("R2 held index", link_tx_data, 8'd0);
        collect(8);
        chk("R3 byte count", ncap, 8);
        for (int i = 0; i < 8; i++) chk("R3 R4 R2 frame byte", cap[i], exp[i]);
    endtask

    task automatic t_tx_full();
        for (int i = 0; i < DP; i++) push_tx(3, 8'h10 + 8'(i));
        #1;
        chk("R6 ch3 full", usr_tx_ready[3], 1'b0);
        chk("R6 others free", usr_tx_ready[2:0], 3'b111);
        collect(2 * DP);
        for (int i = 0; i < DP; i++) begin
            chk("R5 index", cap[2*i], 8'd3);
            chk("R5 order", cap[2*i+1], 8'h10 + 8'(i));
        end
        #1;
        chk("R6 ch3 free again", usr_tx_ready[3], 1'b1);
    endtask

    task automatic t_rx_route();
        send_rx(8'd2); send_rx(8'h78);
        send_rx(8'd0); send_rx(8'h79);
        send_rx(8'd2); send_rx(8'h7A);
        @(negedge clk);
        chk("R8 empty channels", {usr_rx_valid[3], usr_rx_valid[1]}, 2'b00);
        pop_rx(2, 8'h78, "R7");
        pop_rx(2, 8'h7A, "R7");
        pop_rx(0, 8'h79, "R7");
        @(negedge clk);
        chk("R8 all drained", usr_rx_valid, '0);
    endtask

    task automatic t_rx_ctl();
        send_rx(8'd1); send_rx(8'h03);
        chk("R9 intr pulse", {ev_intr, ev_eof, ev_susp}, {4'b0010, 4'b0, 4'b0});
        @(posedge clk); #0.5;
        chk("R9 pulse ends", {ev_intr, ev_eof, ev_susp}, '0);
        send_rx(8'd3); send_rx(8'h04);
        chk("R9 eof pulse", {ev_intr, ev_eof, ev_susp}, {4'b0, 4'b1000, 4'b0});
        send_rx(8'd0); send_rx(8'h1A);
        chk("R9 susp pulse", {ev_intr, ev_eof, ev_susp}, {4'b0, 4'b0, 4'b0001});
        @(negedge clk);
        chk("R9 nothing queued", usr_rx_valid, '0);
    endtask

    task automatic t_rx_badidx();
        send_rx(8'd7); send_rx(8'h71);
        chk("R10 no event", {ev_intr, ev_eof, ev_susp}, '0);
        @(negedge clk);
        chk("R10 nothing queued", usr_rx_valid, '0);
        send_rx(8'd1); send_rx(8'h6B);
        pop_rx(1, 8'h6B, "R10");
    endtask

    task automatic t_rx_stall();
        for (int i = 0; i < DP; i++) begin
            send_rx(8'd3);
            send_rx(8'h50 + 8'(i));
        end
        send_rx(8'd3);
        @(negedge clk);
        link_rx_valid = 1'b1;
        link_rx_data = 8'h5F;
        for (int i = 0; i < 3; i++) begin
            #2;
            chk("R11 stalled", link_rx_ready, 1'b0);
            @(negedge clk);
        end
        #1;
        chk("R11 head kept", usr_rx_data[3*8 +: 8], 8'h50);
        usr_rx_ready[3] = 1'b1;
        @(posedge clk); #0.5;
        usr_rx_ready[3] = 1'b0;
        #0.5;
        chk("R11 released", link_rx_ready, 1'b1);
        @(posedge clk); #0.5;
        link_rx_valid = 1'b0;
        for (int i = 1; i < DP; i++) pop_rx(3, 8'h50 + 8'(i), "R11");
        pop_rx(3, 8'h5F, "R11");
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_rr();
        t_tx_full();
        t_rx_route();
        t_rx_ctl();
        t_rx_badidx();
        t_rx_stall();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule